// File: doc/BRIEF.md
# MII / Serial-Mode Interface Selector

This block sits on the PHY side of the MAC-facing pins. It connects a PHY core, which presents receive data and activity and accepts transmit data, to one set of pins. Those pins carry either a 4-bit nibble interface or a 10 Mbps seven-wire serial interface in which only bit 0 of each data bus moves. A strap input picks the personality while reset is asserted. The choice is frozen when reset is released and holds until the next reset.

The block runs from one clock. In nibble mode one nibble crosses in each direction on every clock, and every output is registered once. In serial mode the clock runs at twice the serial bit rate, so one clock period is half a bit time. While the link is up, the block produces a serial clock that toggles on every clock edge. Data bit 0 moves in each direction only on the edges where that serial clock rises. All other data and error outputs are held low.

Carrier sense is raised for transmit or receive activity. In serial mode it stays high for three more half-bit periods (1.5 bit times) after activity stops. A receiving MAC therefore sees one or two trailing dribble bits, depending on the serial clock phase when activity stops.

Top module: `mii_serial_selector`

## Requirements
- R1: `serial_mode` is 1 (serial) when `mode_strap` is low on the last clock edge with `rst_n` low, and 0 (nibble) when it is high. After reset is released it does not change, whatever `mode_strap` does.
- R2: In nibble mode, `mii_rxd`, `mii_rx_dv` and `mii_rx_er` equal `phy_rxd`, `phy_rx_valid` and `phy_rx_err` from the previous clock edge.
- R3: In nibble mode, `phy_txd`, `phy_tx_en` and `phy_tx_er` equal `mac_txd`, `mac_tx_en` and `mac_tx_er` from the previous clock edge.
- R4: In serial mode with `link_up` high, `ser_clk` inverts on every clock edge, starting from 0 after reset. It is 0 in nibble mode and on every edge where `link_up` is low.
- R5: In serial mode, `mii_rxd[0]` takes `phy_rxd[0]` only on an edge where `ser_clk` goes from 0 to 1, and otherwise holds. `mii_rxd[3:1]`, `mii_rx_dv` and `mii_rx_er` are 0.
- R6: In serial mode, `phy_txd[0]` and `phy_tx_en` take `mac_txd[0]` and `mac_tx_en` only on an edge where `ser_clk` rises. `phy_txd[3:1]` and `phy_tx_er` are 0, and `mac_txd[3:1]` and `mac_tx_er` have no effect.
- R7: `mii_crs` is 1 on the clock after any edge where `mac_tx_en` or `phy_rx_valid` is high. In nibble mode it is 0 on the clock after an edge where both are low.
- R8: In serial mode, after the last edge with activity, `mii_crs` stays 1 for exactly 3 more clocks (1.5 bit times). That tail contains 2 rising `ser_clk` edges if `ser_clk` was 0 when activity stopped, and 1 if it was 1.
- R9: In serial mode with `link_up` low, no data is captured: serial data and transmit-enable outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; nibble rate, or twice the bit rate in serial mode |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Personality strap, sampled during reset; low selects serial |
| link_up | input | 1 | Link status from the PHY core; gates the serial clock |
| phy_rxd | input | 4 | Receive data from the PHY core |
| phy_rx_valid | input | 1 | Receive data valid / receive activity from the PHY core |
| phy_rx_err | input | 1 | Receive error from the PHY core |
| mac_txd | input | 4 | Transmit data from the MAC |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_tx_er | input | 1 | Transmit error from the MAC |
| mii_rxd | output | 4 | Receive data to the MAC |
| mii_rx_dv | output | 1 | Receive data valid to the MAC |
| mii_rx_er | output | 1 | Receive error to the MAC |
| mii_crs | output | 1 | Carrier sense to the MAC |
| ser_clk | output | 1 | Serial-mode bit clock |
| phy_txd | output | 4 | Transmit data to the PHY core |
| phy_tx_en | output | 1 | Transmit enable to the PHY core |
| phy_tx_er | output | 1 | Transmit error to the PHY core |
| serial_mode | output | 1 | Latched personality, 1 = serial |

## Verification
A wrong latched personality shows on the first clock after reset: `serial_mode` is wrong, and within one more edge the upper data bits and `ser_clk` behave like the other mode. A serial clock in the wrong phase moves every capture edge by one clock, so `mii_rxd[0]` and `phy_txd[0]` differ from the expected values within two clocks of any data change. It also swaps the dribble count, 1 for 2, in the carrier tail. A corrupted tail counter shows as a carrier sense that falls one or more clocks early or late after the first frame ends.

// File: rtl/mif_pkg.sv
// Package: shared types and constants for the interface selector.
// Assumes one block clock; in serial mode that clock is twice the bit rate.
package mif_pkg;
    typedef enum logic {
        IFM_NIBBLE = 1'b0,
        IFM_SERIAL = 1'b1
    } if_mode_e;

    // Carrier tail in serial mode, in half-bit clocks (1.5 bit times).
    localparam int unsigned CRS_TAIL_HALVES = 3;
endpackage

// File: rtl/mif_strap_latch.sv
// Strap latch: while reset is asserted it follows the strap pin (low = serial).
// The value on the last reset edge is then held until the next reset.
module mif_strap_latch
    import mif_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strap_i,
    output if_mode_e mode_o
);
    if_mode_e mode_q;

    // Sample the strap during reset, freeze it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= strap_i ? IFM_NIBBLE : IFM_SERIAL;
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/mif_serial_clk.sv
// Serial clock generator: toggles every clock while enabled, otherwise held low.
// The strobe marks the edge on which the serial clock rises (data capture edge).
module mif_serial_clk (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic strobe_o
);
    logic sclk_q;

    // Divide-by-two toggle, parked low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n)     sclk_q <= 1'b0;
        else if (run_i) sclk_q <= ~sclk_q;
        else            sclk_q <= 1'b0;
    end

    assign sclk_o   = sclk_q;
    assign strobe_o = run_i && !sclk_q;
endmodule

// File: rtl/mif_datapath.sv
// Data path: registers receive and transmit lanes. In nibble mode every lane
// passes each clock. In serial mode lane 0 moves only on the strobe and the
// upper lanes and error bits are forced low.
module mif_datapath #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_i,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] rx_d_i,
    input  logic              rx_v_i,
    input  logic              rx_e_i,
    input  logic [DATA_W-1:0] tx_d_i,
    input  logic              tx_en_i,
    input  logic              tx_er_i,
    output logic [DATA_W-1:0] rx_d_o,
    output logic              rx_v_o,
    output logic              rx_e_o,
    output logic [DATA_W-1:0] tx_d_o,
    output logic              tx_en_o,
    output logic              tx_er_o
);
    logic [DATA_W-1:0] rx_d_q;
    logic [DATA_W-1:0] tx_d_q;
    logic              rx_v_q, rx_e_q, tx_en_q, tx_er_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        if (i == 0) begin : g_ser_lane
            // Lane 0: every clock in nibble mode, strobe only in serial mode.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rx_d_q[i] <= 1'b0;
                    tx_d_q[i] <= 1'b0;
                end else if (!serial_i || strobe_i) begin
                    rx_d_q[i] <= rx_d_i[i];
                    tx_d_q[i] <= tx_d_i[i];
                end
            end
        end else begin : g_nib_lane
            // Upper lanes: nibble mode only, zero in serial mode.
            always_ff @(posedge clk) begin
                if (!rst_n || serial_i) begin
                    rx_d_q[i] <= 1'b0;
                    tx_d_q[i] <= 1'b0;
                end else begin
                    rx_d_q[i] <= rx_d_i[i];
                    tx_d_q[i] <= tx_d_i[i];
                end
            end
        end
    end

    // Framing and error bits; only transmit enable survives in serial mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_v_q  <= 1'b0;
            rx_e_q  <= 1'b0;
            tx_en_q <= 1'b0;
            tx_er_q <= 1'b0;
        end else if (!serial_i) begin
            rx_v_q  <= rx_v_i;
            rx_e_q  <= rx_e_i;
            tx_en_q <= tx_en_i;
            tx_er_q <= tx_er_i;
        end else begin
            rx_v_q  <= 1'b0;
            rx_e_q  <= 1'b0;
            tx_er_q <= 1'b0;
            if (strobe_i) tx_en_q <= tx_en_i;
        end
    end

    assign rx_d_o  = rx_d_q;
    assign rx_v_o  = rx_v_q;
    assign rx_e_o  = rx_e_q;
    assign tx_d_o  = tx_d_q;
    assign tx_en_o = tx_en_q;
    assign tx_er_o = tx_er_q;
endmodule

// File: rtl/mif_crs_gen.sv
// Carrier sense: high after any activity. In serial mode it is held TAIL more
// clocks once activity stops; in nibble mode it drops at once.
module mif_crs_gen #(
    parameter int unsigned TAIL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic serial_i,
    input  logic act_i,
    output logic crs_o
);
    localparam int unsigned CNT_W = $clog2(TAIL + 1);

    logic [CNT_W-1:0] tail_q;
    logic             crs_q;

    // Reload the tail on activity, count it out when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
            crs_q  <= 1'b0;
        end else if (act_i) begin
            tail_q <= serial_i ? CNT_W'(TAIL) : '0;
            crs_q  <= 1'b1;
        end else if (tail_q != '0) begin
            tail_q <= tail_q - 1'b1;
            crs_q  <= 1'b1;
        end else begin
            crs_q  <= 1'b0;
        end
    end

    assign crs_o = crs_q;
endmodule

// File: rtl/mii_serial_selector.sv
// Top: selects nibble or serial personality from a reset-time strap and routes
// data, framing and carrier sense between the PHY core and the MAC pins.
// Assumes link_up and all data inputs are synchronous to clk.
module mii_serial_selector
    import mif_pkg::*;
#(
    parameter int unsigned DATA_W = 4,
    parameter int unsigned TAIL   = CRS_TAIL_HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic              link_up,
    input  logic [DATA_W-1:0] phy_rxd,
    input  logic              phy_rx_valid,
    input  logic              phy_rx_err,
    input  logic [DATA_W-1:0] mac_txd,
    input  logic              mac_tx_en,
    input  logic              mac_tx_er,
    output logic [DATA_W-1:0] mii_rxd,
    output logic              mii_rx_dv,
    output logic              mii_rx_er,
    output logic              mii_crs,
    output logic              ser_clk,
    output logic [DATA_W-1:0] phy_txd,
    output logic              phy_tx_en,
    output logic              phy_tx_er,
    output logic              serial_mode
);
    if_mode_e mode;
    logic     is_serial;
    logic     strobe;

    mif_strap_latch u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (mode_strap),
        .mode_o  (mode)
    );

    assign is_serial   = (mode == IFM_SERIAL);
    assign serial_mode = is_serial;

    mif_serial_clk u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (is_serial && link_up),
        .sclk_o   (ser_clk),
        .strobe_o (strobe)
    );

    mif_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .serial_i (is_serial),
        .strobe_i (strobe),
        .rx_d_i   (phy_rxd),
        .rx_v_i   (phy_rx_valid),
        .rx_e_i   (phy_rx_err),
        .tx_d_i   (mac_txd),
        .tx_en_i  (mac_tx_en),
        .tx_er_i  (mac_tx_er),
        .rx_d_o   (mii_rxd),
        .rx_v_o   (mii_rx_dv),
        .rx_e_o   (mii_rx_er),
        .tx_d_o   (phy_txd),
        .tx_en_o  (phy_tx_en),
        .tx_er_o  (phy_tx_er)
    );

    mif_crs_gen #(.TAIL(TAIL)) u_crs (
        .clk      (clk),
        .rst_n    (rst_n),
        .serial_i (is_serial),
        .act_i    (mac_tx_en || phy_rx_valid),
        .crs_o    (mii_crs)
    );
endmodule

// File: rtl/mif_checker.sv
// Checker: port-level temporal properties of the interface selector.
module mif_checker #(
    parameter int unsigned DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_up,
    input logic [DATA_W-1:0] phy_rxd,
    input logic              phy_rx_valid,
    input logic [DATA_W-1:0] mac_txd,
    input logic              mac_tx_en,
    input logic [DATA_W-1:0] mii_rxd,
    input logic              mii_rx_dv,
    input logic              mii_rx_er,
    input logic              mii_crs,
    input logic              ser_clk,
    input logic [DATA_W-1:0] phy_txd,
    input logic              phy_tx_en,
    input logic              phy_tx_er,
    input logic              serial_mode
);
    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(serial_mode));

    a_r2_nibble_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && phy_rx_valid) |=> (mii_rx_dv && mii_rxd == $past(phy_rxd)));

    a_r3_nibble_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && mac_tx_en) |=> (phy_tx_en && phy_txd == $past(mac_txd)));

    a_r4_sclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && link_up) |=> (ser_clk != $past(ser_clk)));

    a_r4_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode || !link_up) |=> !ser_clk);

    a_r5_serial_rx_upper: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |-> (mii_rxd[DATA_W-1:1] == '0 && !mii_rx_dv && !mii_rx_er));

    a_r6_serial_tx_upper: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |-> (phy_txd[DATA_W-1:1] == '0 && !phy_tx_er));

    a_r7_crs_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_tx_en || phy_rx_valid) |=> mii_crs);

    a_r7_crs_nibble_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!serial_mode && !mac_tx_en && !phy_rx_valid) |=> !mii_crs);

    a_r9_link_down_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && !link_up) |=> ($stable(mii_rxd) && $stable(phy_txd) && $stable(phy_tx_en)));
endmodule

bind mii_serial_selector mif_checker #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_up      (link_up),
    .phy_rxd      (phy_rxd),
    .phy_rx_valid (phy_rx_valid),
    .mac_txd      (mac_txd),
    .mac_tx_en    (mac_tx_en),
    .mii_rxd      (mii_rxd),
    .mii_rx_dv    (mii_rx_dv),
    .mii_rx_er    (mii_rx_er),
    .mii_crs      (mii_crs),
    .ser_clk      (ser_clk),
    .phy_txd      (phy_txd),
    .phy_tx_en    (phy_tx_en),
    .phy_tx_er    (phy_tx_er),
    .serial_mode  (serial_mode)
);

// File: tb/mii_serial_selector_tb_top.sv
// Bench: sweeps both personalities. A per-edge model built from the
// requirements is compared at every falling edge.
module mii_serial_selector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_strap = 1'b1;
    logic       link_up = 1'b0;
    logic [3:0] phy_rxd = '0;
    logic       phy_rx_valid = 1'b0;
    logic       phy_rx_err = 1'b0;
    logic [3:0] mac_txd = '0;
    logic       mac_tx_en = 1'b0;
    logic       mac_tx_er = 1'b0;
    logic [3:0] mii_rxd;
    logic       mii_rx_dv, mii_rx_er, mii_crs, ser_clk;
    logic [3:0] phy_txd;
    logic       phy_tx_en, phy_tx_er, serial_mode;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic       e_mode = 1'b0;
    logic       e_clk  = 1'b0;
    logic [5:0] e_rx   = '0;
    logic [5:0] e_tx   = '0;
    logic [3:0] hist   = '0;
    logic       e_crs  = 1'b0;

    always #2 clk = ~clk;

    mii_serial_selector dut_i (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .link_up(link_up),
        .phy_rxd(phy_rxd), .phy_rx_valid(phy_rx_valid), .phy_rx_err(phy_rx_err),
        .mac_txd(mac_txd), .mac_tx_en(mac_tx_en), .mac_tx_er(mac_tx_er),
        .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er),
        .mii_crs(mii_crs), .ser_clk(ser_clk), .phy_txd(phy_txd),
        .phy_tx_en(phy_tx_en), .phy_tx_er(phy_tx_er), .serial_mode(serial_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the model at the rising edge, compare at the falling edge.
    task automatic cycle();
        logic act, strobe;
        @(posedge clk);
        act = mac_tx_en || phy_rx_valid;
        if (!rst_n) begin
            e_mode = !mode_strap; e_clk = 1'b0; e_rx = '0; e_tx = '0;
            hist = '0; e_crs = 1'b0;
        end else if (!e_mode) begin
            e_clk = 1'b0;
            e_rx  = {phy_rxd, phy_rx_valid, phy_rx_err};
            e_tx  = {mac_txd, mac_tx_en, mac_tx_er};
            hist  = {hist[2:0], act};
            e_crs = act;
        end else begin
            strobe = link_up && !e_clk;
            e_clk  = link_up ? !e_clk : 1'b0;
            if (strobe) begin
                e_rx = {3'b000, phy_rxd[0], 2'b00};
                e_tx = {3'b000, mac_txd[0], mac_tx_en, 1'b0};
            end
            hist  = {hist[2:0], act};
            e_crs = |hist;
        end
        @(negedge clk);
        chk("R1 mode", {7'd0, serial_mode}, {7'd0, e_mode});
        chk(e_mode ? (link_up ? "R5 serial rx" : "R9 rx hold") : "R2 nibble rx",
            {2'd0, mii_rxd, mii_rx_dv, mii_rx_er}, {2'd0, e_rx});
        chk(e_mode ? (link_up ? "R6 serial tx" : "R9 tx hold") : "R3 nibble tx",
            {2'd0, phy_txd, phy_tx_en, phy_tx_er}, {2'd0, e_tx});
        chk("R4 ser_clk", {7'd0, ser_clk}, {7'd0, e_clk});
        chk(e_mode ? "R8 crs" : "R7 crs", {7'd0, mii_crs}, {7'd0, e_crs});
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0; mode_strap = strap;
        phy_rx_valid = 1'b0; mac_tx_en = 1'b0;
        repeat (3) cycle();
        rst_n = 1'b1;
    endtask

    task automatic sweep(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] p;
            p = 8'(i * 37 + 11);
            phy_rxd = p[3:0]; phy_rx_valid = p[4]; phy_rx_err = p[5];
            mac_txd = ~p[3:0]; mac_tx_en = p[6]; mac_tx_er = p[7] ^ p[0];
            cycle();
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Nibble personality (R1, R2, R3, R7)
        do_reset(1'b1);
        link_up = 1'b1;
        sweep(256);
        phy_rx_valid = 1'b0; mac_tx_en = 1'b0;
        repeat (3) cycle();          // R7 idle drops at once
        mode_strap = 1'b0;           // R1 strap ignored after reset
        sweep(32);
        link_up = 1'b0;              // R4 ser_clk stays low
        sweep(8);

        // Serial personality (R1, R4, R5, R6, R8, R9)
        do_reset(1'b0);
        link_up = 1'b1;
        sweep(256);
        link_up = 1'b0;              // R9 hold while link down
        sweep(12);
        link_up = 1'b1;
        mode_strap = 1'b1;           // R1 strap ignored after reset
        sweep(64);

        // R8 carrier tail in both serial clock phases
        for (int ph = 0; ph < 2; ph++) begin
            logic c_before, prev;
            int   crs_len, rises;
            phy_rx_valid = 1'b1; mac_tx_en = 1'b0;
            repeat (4 + ph) cycle();
            phy_rx_valid = 1'b0;
            c_before = ser_clk;
            prev = ser_clk;
            crs_len = 0; rises = 0;
            repeat (6) begin
                cycle();
                if (mii_crs) begin
                    crs_len++;
                    if (ser_clk && !prev) rises++;
                end
                prev = ser_clk;
            end
            chk("R8 tail length", 8'(crs_len), 8'd3);
            chk("R8 dribble edges", 8'(rises), c_before ? 8'd1 : 8'd2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule